// File: doc/BRIEF.md
# Byte-wise flash access engine

This block is a programmed-I/O engine that moves exactly one byte between a serial NOR flash and a small register bus for each command. Software first picks a read style (plain single-lane, fast single-lane, dual-output or quad-output, optionally with the address sent on two or four lanes), places the read opcode in one of two opcode registers, and loads a 3- or 4-byte flash address once. After that, each read command fetches the next byte into a result register, and each write command programs the byte held in an outgoing-data register. The internal address then steps by one, so a run of commands walks through consecutive flash bytes without reloading the address.

The serial side runs at half the system clock. The sequencer passes through the states IDLE, OPC (opcode), ADR (address), DUM (dummy clocks), DAT (data) and FIN (chip-select released, one cycle). Its transitions are IDLE to OPC on an accepted command, OPC to ADR, ADR to DUM for reads that need dummy clocks, ADR to DAT otherwise, DUM to DAT, DAT to FIN, and FIN to IDLE. The command register reads back its value while the transfer runs and reads zero once FIN has been left, which is how software detects completion.

Register offsets on the 4-bit bus: 0 command, 1 read result (read only), 2 outgoing data, 3 to 6 address bytes (3 is least significant; reads return the live address), 7 opcode for single/dual reads, 8 opcode for quad reads, 9 fast-read enable (bit 0), 10 lane/width mode.

Top module: `nor_pio_engine`

## Requirements
- R1: After reset the command register and all address bytes read 0, fl_cs_n is 1, fl_sck is 0 and fl_io_oe is 0.
- R2: Writing 0x81 to the command register starts one byte read and writing 0x90 starts one byte write; while the transfer runs the register reads back that value and it reads 0 after completion. Any other value starts nothing, and every bus write is ignored while a transfer runs.
- R3: A read sends its opcode first, MSB first on fl_io_out[0]: taken from register 8 when mode bit 2 is set, otherwise from register 7.
- R4: The address follows the opcode MSB first, 32 bits when mode bit 4 is set, otherwise the low 24 bits.
- R5: For reads the address uses 4 lanes when mode bit 3 is set, else 2 lanes when mode bit 1 is set, else 1 lane; on multiple lanes the highest-numbered lane carries the most significant bit of each group.
- R6: A read inserts 8 dummy clocks after the address when register 9 bit 0 is set or mode bit 0 or bit 2 is set, and none otherwise.
- R7: Read data is taken on 4 lanes when mode bit 2 is set, else on fl_io_in[1:0] when mode bit 0 is set, else on fl_io_in[1] alone; bits arrive MSB first and the byte is placed in register 1.
- R8: A write sends opcode 0x02, then the address on one lane, then the byte from register 2 on fl_io_out[0], all within a single chip-select assertion, ignoring the lane bits 0 to 3 of the mode.
- R9: fl_io_oe is non-zero only during the opcode and address phases and the data phase of a write; it is 0 during dummy clocks, read data and while fl_cs_n is high.
- R10: Each completed command advances the address by one, readable through registers 3 to 6, so consecutive commands access consecutive bytes.
- R11: With mode bit 4 clear the low 24 address bits wrap from 0xFFFFFF to 0 and bits 31:24 hold; with it set the full 32-bit address wraps to 0.
- R12: Each command makes exactly one chip-select assertion; fl_sck is low whenever fl_cs_n is high, and data changes while fl_sck is low and is sampled while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset for reads and writes |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr (combinational) |
| fl_sck | output | 1 | Serial clock to the flash |
| fl_cs_n | output | 1 | Active-low flash chip select |
| fl_io_out | output | 4 | Values driven on the four data lanes |
| fl_io_oe | output | 4 | Per-lane output enables |
| fl_io_in | input | 4 | Values sampled from the four data lanes |

## Verification
The bench targets the lane-width decisions: opcode register choice in quad mode, dual and quad address packing, 4-byte addressing and the dummy-clock rule; a design that mixed up lane order or picked the wrong opcode register would show a wrong opcode or address in the recorded serial trace or a scrambled result byte. Address stepping is checked across consecutive commands and at both wrap points, where a counter that ignored the width bit would carry into bit 24 or fail to wrap. Rejected command values and the busy readback are exercised, since an engine that started on any value or cleared its command register early would emit a stray chip-select or report completion too soon. Write transfers are checked for the fixed program opcode and single-lane data regardless of the read-lane bits.

// File: rtl/nor_pio_pkg.sv
package nor_pio_pkg;

    localparam logic [3:0] A_CMD    = 4'd0;
    localparam logic [3:0] A_RDATA  = 4'd1;
    localparam logic [3:0] A_WDATA  = 4'd2;
    localparam logic [3:0] A_ADR0   = 4'd3;
    localparam logic [3:0] A_OPC_SD = 4'd7;
    localparam logic [3:0] A_OPC_Q  = 4'd8;
    localparam logic [3:0] A_FAST   = 4'd9;
    localparam logic [3:0] A_MODE   = 4'd10;

    localparam logic [7:0] CMD_RD  = 8'h81;
    localparam logic [7:0] CMD_WR  = 8'h90;
    localparam logic [7:0] OP_PROG = 8'h02;

    localparam int M_DUAL_RD = 0;
    localparam int M_DUAL_AD = 1;
    localparam int M_QUAD_RD = 2;
    localparam int M_QUAD_AD = 3;
    localparam int M_ADDR4   = 4;

    typedef enum logic [2:0] {
        S_IDLE, S_OPC, S_ADR, S_DUM, S_DAT, S_FIN
    } seq_state_t;

    // lane width code: 0 -> 1 lane, 1 -> 2 lanes, 2 -> 4 lanes
    typedef logic [1:0] lane_code_t;

endpackage

// File: rtl/nor_pio_regs.sv
module nor_pio_regs
    import nor_pio_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              busy,
    input  logic              done,
    input  logic [7:0]        rx_byte,
    input  logic [ADDR_W-1:0] addr,
    output logic              start,
    output logic              is_read,
    output logic [7:0]        wdata,
    output logic [7:0]        opc_sd,
    output logic [7:0]        opc_q,
    output logic              fast,
    output logic [4:0]        mode,
    output logic              ld_en,
    output logic [1:0]        ld_idx,
    output logic [7:0]        cmd_q,
    output logic [7:0]        bus_rdata
);
    localparam int NBYTES = ADDR_W / 8;

    logic       wr_ok;
    logic [7:0] rdata_q;
    logic [3:0] rel;

    assign wr_ok   = bus_wr && !busy;
    assign is_read = (bus_wdata == CMD_RD);
    assign start   = wr_ok && (bus_addr == A_CMD) &&
                     ((bus_wdata == CMD_RD) || (bus_wdata == CMD_WR));
    assign rel     = bus_addr - A_ADR0;
    assign ld_en   = wr_ok && (bus_addr >= A_ADR0) && (rel < 4'(NBYTES));
    assign ld_idx  = rel[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            rdata_q <= '0;
            wdata   <= '0;
            opc_sd  <= '0;
            opc_q   <= '0;
            fast    <= 1'b0;
            mode    <= '0;
        end else begin
            if (start) cmd_q <= bus_wdata;
            if (done) begin
                cmd_q <= '0;
                if (cmd_q == CMD_RD) rdata_q <= rx_byte;
            end
            if (wr_ok) begin
                case (bus_addr)
                    A_WDATA:  wdata  <= bus_wdata;
                    A_OPC_SD: opc_sd <= bus_wdata;
                    A_OPC_Q:  opc_q  <= bus_wdata;
                    A_FAST:   fast   <= bus_wdata[0];
                    A_MODE:   mode   <= bus_wdata[4:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CMD:    bus_rdata = cmd_q;
            A_RDATA:  bus_rdata = rdata_q;
            A_WDATA:  bus_rdata = wdata;
            A_OPC_SD: bus_rdata = opc_sd;
            A_OPC_Q:  bus_rdata = opc_q;
            A_FAST:   bus_rdata = {7'd0, fast};
            A_MODE:   bus_rdata = {3'd0, mode};
            default: begin
                if (bus_addr >= A_ADR0 && rel < 4'(NBYTES))
                    bus_rdata = addr[8*ld_idx +: 8];
            end
        endcase
    end
endmodule

// File: rtl/nor_pio_addr.sv
module nor_pio_addr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [1:0]        ld_idx,
    input  logic [7:0]        ld_byte,
    input  logic              step,
    input  logic              wide,
    output logic [ADDR_W-1:0] addr
);
    localparam int NARROW_W = ADDR_W - 8;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (ld_en) begin
            addr[8*ld_idx +: 8] <= ld_byte;
        end else if (step) begin
            if (wide)
                addr <= addr + 1'b1;
            else
                addr <= {addr[ADDR_W-1:NARROW_W], addr[NARROW_W-1:0] + 1'b1};
        end
    end
endmodule

// File: rtl/nor_pio_seq.sv
module nor_pio_seq
    import nor_pio_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DUMMY_CLKS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [7:0]        opc_sd,
    input  logic [7:0]        opc_q,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] addr,
    input  logic              fast,
    input  logic [4:0]        mode,
    input  logic [3:0]        io_in,
    output logic              sck,
    output logic              cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    output logic              busy,
    output logic              done,
    output logic              rd_data_phase,
    output logic [7:0]        rx_byte
);
    localparam int NARROW_W = ADDR_W - 8;
    localparam int CNT_W    = $clog2(ADDR_W + 1) + 1;

    seq_state_t  state;
    logic        half;
    logic        rd_q;
    lane_code_t  lanes;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] shreg;
    logic [7:0]  rx;

    lane_code_t  dlanes, alanes;
    logic        need_dummy;
    logic [7:0]  opc_sel;
    logic [CNT_W-1:0] abits;

    assign dlanes     = mode[M_QUAD_RD] ? 2'd2 : (mode[M_DUAL_RD] ? 2'd1 : 2'd0);
    assign alanes     = mode[M_QUAD_AD] ? 2'd2 : (mode[M_DUAL_AD] ? 2'd1 : 2'd0);
    assign need_dummy = fast || mode[M_DUAL_RD] || mode[M_QUAD_RD];
    assign opc_sel    = !is_read ? OP_PROG : (mode[M_QUAD_RD] ? opc_q : opc_sd);
    assign abits      = mode[M_ADDR4] ? CNT_W'(ADDR_W) : CNT_W'(NARROW_W);

    function automatic logic [ADDR_W-1:0] shift_out(logic [ADDR_W-1:0] v, lane_code_t lc);
        case (lc)
            2'd0:    return {v[ADDR_W-2:0], 1'b0};
            2'd1:    return {v[ADDR_W-3:0], 2'b0};
            default: return {v[ADDR_W-5:0], 4'b0};
        endcase
    endfunction

    function automatic logic [7:0] shift_in(logic [7:0] v, logic [3:0] pins, lane_code_t lc);
        case (lc)
            2'd0:    return {v[6:0], pins[1]};
            2'd1:    return {v[5:0], pins[1:0]};
            default: return {v[3:0], pins};
        endcase
    endfunction

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            half  <= 1'b0;
            rd_q  <= 1'b0;
            lanes <= 2'd0;
            cnt   <= '0;
            shreg <= '0;
            rx    <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        state <= S_OPC;
                        rd_q  <= is_read;
                        shreg <= {opc_sel, {(ADDR_W-8){1'b0}}};
                        lanes <= 2'd0;
                        cnt   <= CNT_W'(8);
                        half  <= 1'b0;
                    end
                end
                S_FIN: state <= S_IDLE;
                S_OPC, S_ADR, S_DUM, S_DAT: begin
                    if (!half) begin
                        half <= 1'b1;
                    end else begin
                        half  <= 1'b0;
                        shreg <= shift_out(shreg, lanes);
                        cnt   <= cnt - 1'b1;
                        if (state == S_DAT && rd_q) rx <= shift_in(rx, io_in, lanes);
                        if (cnt == CNT_W'(1)) begin
                            case (state)
                                S_OPC: begin
                                    state <= S_ADR;
                                    shreg <= mode[M_ADDR4] ? addr
                                                           : {addr[NARROW_W-1:0], 8'h00};
                                    lanes <= rd_q ? alanes : 2'd0;
                                    cnt   <= abits >> (rd_q ? alanes : 2'd0);
                                end
                                S_ADR, S_DUM: begin
                                    if (state == S_ADR && rd_q && need_dummy) begin
                                        state <= S_DUM;
                                        lanes <= 2'd0;
                                        cnt   <= CNT_W'(DUMMY_CLKS);
                                    end else if (rd_q) begin
                                        state <= S_DAT;
                                        lanes <= dlanes;
                                        cnt   <= CNT_W'(8) >> dlanes;
                                        rx    <= '0;
                                    end else begin
                                        state <= S_DAT;
                                        lanes <= 2'd0;
                                        shreg <= {wdata, {(ADDR_W-8){1'b0}}};
                                        cnt   <= CNT_W'(8);
                                    end
                                end
                                default: state <= S_FIN;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sck           = 1'b0;
        cs_n          = 1'b1;
        io_out        = 4'd0;
        io_oe         = 4'd0;
        busy          = (state != S_IDLE);
        done          = (state == S_FIN);
        rd_data_phase = (state == S_DAT) && rd_q;
        rx_byte       = rx;
        unique case (state)
            S_IDLE, S_FIN: ;
            S_OPC, S_ADR, S_DUM, S_DAT: begin
                cs_n = 1'b0;
                sck  = half;
                case (lanes)
                    2'd0:    io_out = {3'd0, shreg[ADDR_W-1]};
                    2'd1:    io_out = {2'd0, shreg[ADDR_W-1:ADDR_W-2]};
                    default: io_out = shreg[ADDR_W-1:ADDR_W-4];
                endcase
                if (state == S_OPC || state == S_ADR || (state == S_DAT && !rd_q)) begin
                    case (lanes)
                        2'd0:    io_oe = 4'b0001;
                        2'd1:    io_oe = 4'b0011;
                        default: io_oe = 4'b1111;
                    endcase
                end
            end
        endcase
    end
endmodule

// File: rtl/nor_pio_engine.sv
module nor_pio_engine
    import nor_pio_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DUMMY_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [3:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       fl_sck,
    output logic       fl_cs_n,
    output logic [3:0] fl_io_out,
    output logic [3:0] fl_io_oe,
    input  logic [3:0] fl_io_in
);
    logic              start, is_read, fast, ld_en, busy, done, rd_data_phase;
    logic [7:0]        wdata, opc_sd, opc_q, rx_byte, cmd_q;
    logic [4:0]        mode;
    logic [1:0]        ld_idx;
    logic [ADDR_W-1:0] addr;

    nor_pio_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .busy(busy), .done(done), .rx_byte(rx_byte),
        .addr(addr), .start(start), .is_read(is_read), .wdata(wdata),
        .opc_sd(opc_sd), .opc_q(opc_q), .fast(fast), .mode(mode),
        .ld_en(ld_en), .ld_idx(ld_idx), .cmd_q(cmd_q), .bus_rdata(bus_rdata)
    );

    nor_pio_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_byte(bus_wdata), .step(done), .wide(mode[M_ADDR4]), .addr(addr)
    );

    nor_pio_seq #(.ADDR_W(ADDR_W), .DUMMY_CLKS(DUMMY_CLKS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read),
        .opc_sd(opc_sd), .opc_q(opc_q), .wdata(wdata), .addr(addr),
        .fast(fast), .mode(mode), .io_in(fl_io_in), .sck(fl_sck),
        .cs_n(fl_cs_n), .io_out(fl_io_out), .io_oe(fl_io_oe), .busy(busy),
        .done(done), .rd_data_phase(rd_data_phase), .rx_byte(rx_byte)
    );
endmodule

// File: rtl/nor_pio_chk.sv
module nor_pio_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fl_sck,
    input logic              fl_cs_n,
    input logic [3:0]        fl_io_oe,
    input logic              busy,
    input logic              rd_data_phase,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        cmd_q
);
    // R12
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_cs_n |-> !fl_sck);

    // R9
    oe_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_cs_n |-> (fl_io_oe == 4'd0));

    // R9
    rd_data_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_phase |-> (fl_io_oe == 4'd0));

    // R10
    step_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (addr[23:0] == $past(addr[23:0]) + 24'd1));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr));

    // R2
    cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (cmd_q == 8'd0));

    // R12
    cs_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_cs_n |-> busy);
endmodule

bind nor_pio_engine nor_pio_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fl_sck(fl_sck), .fl_cs_n(fl_cs_n),
    .fl_io_oe(fl_io_oe), .busy(busy), .rd_data_phase(rd_data_phase),
    .addr(addr), .cmd_q(cmd_q)
);

// File: tb/nor_pio_engine_tb.sv
module nor_pio_engine_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       fl_sck, fl_cs_n;
    logic [3:0] fl_io_out, fl_io_oe;
    logic [3:0] fl_io_in = 4'd0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // flash-side model state
    int         nrise = 0;
    int         cs_falls = 0;
    logic [3:0] tr_out [0:79];
    logic [3:0] tr_oe  [0:79];
    int         m_dstart = 1000;
    int         m_lanes = 1;
    logic [7:0] m_byte = 8'h00;

    nor_pio_engine u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fl_sck(fl_sck),
        .fl_cs_n(fl_cs_n), .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe),
        .fl_io_in(fl_io_in)
    );

    always #10 clk = ~clk;

    function automatic logic [3:0] mbits(int k);
        int j;
        if (k < m_dstart) return 4'd0;
        j = k - m_dstart;
        if (j >= 8 / m_lanes) return 4'd0;
        case (m_lanes)
            4:       return (j == 0) ? m_byte[7:4] : m_byte[3:0];
            2:       return {2'b00, m_byte[7-2*j -: 2]};
            default: return {2'b00, m_byte[7-j], 1'b0};
        endcase
    endfunction

    always @(negedge fl_cs_n) begin
        nrise = 0;
        cs_falls++;
        fl_io_in = 4'd0;
    end

    always @(posedge fl_sck) begin
        if (nrise < 80) begin
            tr_out[nrise] = fl_io_out;
            tr_oe[nrise]  = fl_io_oe;
        end
        nrise++;
        fl_io_in = mbits(nrise - 1);
    end

    function automatic logic [31:0] take(int first, int slots, int lanes);
        logic [31:0] v = 32'd0;
        for (int i = 0; i < slots; i++) begin
            case (lanes)
                4:       v = {v[27:0], tr_out[first+i]};
                2:       v = {v[29:0], tr_out[first+i][1:0]};
                default: v = {v[30:0], tr_out[first+i][0]};
            endcase
        end
        return v;
    endfunction

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic set_addr(logic [31:0] a);
        for (int i = 0; i < 4; i++) bus_write(4'(3 + i), a[8*i +: 8]);
    endtask

    task automatic get_addr(output logic [31:0] a);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            bus_read(4'(3 + i), b);
            a[8*i +: 8] = b;
        end
    endtask

    task automatic run_cmd(logic [7:0] c);
        logic [7:0] v;
        bus_write(4'd0, c);
        for (int i = 0; i < 5000; i++) begin
            bus_read(4'd0, v);
            if (v == 8'd0) break;
        end
    endtask

    task automatic setup(logic [4:0] mode, bit fast, logic [7:0] o3, logic [7:0] o4);
        bus_write(4'd10, {3'd0, mode});
        bus_write(4'd9, {7'd0, fast});
        bus_write(4'd7, o3);
        bus_write(4'd8, o4);
    endtask

    // generic single read with protocol decode
    task automatic do_read(string nm, logic [4:0] mode, bit fast, logic [7:0] o3,
                           logic [7:0] o4, logic [31:0] a, logic [7:0] b,
                           logic [7:0] exp_opc, int alanes, int abits, int dummy, int dlanes);
        logic [7:0]  r;
        logic [31:0] an;
        logic [31:0] exp_next;
        int          aslots;
        int          falls0;
        setup(mode, fast, o3, o4);
        set_addr(a);
        aslots   = abits / alanes;
        m_dstart = 8 + aslots + dummy;
        m_lanes  = dlanes;
        m_byte   = b;
        falls0   = cs_falls;
        run_cmd(8'h81);
        check_eq({nm, " R3 opcode"}, {24'd0, take(0, 8, 1)}, {24'd0, exp_opc});
        check_eq({nm, " R4/R5 address"}, take(8, aslots, alanes),
                 (abits == 32) ? a : {8'd0, a[23:0]});
        check_eq({nm, " R6/R7 clock count"}, nrise, m_dstart + 8 / dlanes);
        bus_read(4'd1, r);
        check_eq({nm, " R7 result byte"}, {24'd0, r}, {24'd0, b});
        check_eq({nm, " R9 oe in data"}, {28'd0, tr_oe[m_dstart]}, 32'd0);
        check_eq({nm, " R12 one cs"}, cs_falls - falls0, 1);
        get_addr(an);
        exp_next = (abits == 32) ? a + 32'd1 : {a[31:24], a[23:0] + 24'd1};
        check_eq({nm, " R10 step"}, an, exp_next);
        m_dstart = 1000;
    endtask

    task automatic t_reset();
        logic [7:0]  v;
        logic [31:0] a;
        bus_read(4'd0, v);
        check_eq("R1 cmd", {24'd0, v}, 32'd0);
        check_eq("R1 cs_n", {31'd0, fl_cs_n}, 32'd1);
        check_eq("R1 sck", {31'd0, fl_sck}, 32'd0);
        check_eq("R1 oe", {28'd0, fl_io_oe}, 32'd0);
        get_addr(a);
        check_eq("R1 addr", a, 32'd0);
    endtask

    task automatic t_single_fast();
        do_read("single-fast", 5'h00, 1'b1, 8'h0B, 8'hEB, 32'h00123456, 8'hA5,
                8'h0B, 1, 24, 8, 1);
    endtask

    task automatic t_plain();
        do_read("plain", 5'h00, 1'b0, 8'h03, 8'hEB, 32'h00ABCDEF, 8'h5A,
                8'h03, 1, 24, 0, 1);
    endtask

    task automatic t_dual();
        do_read("dual", 5'h01, 1'b0, 8'h3B, 8'hEB, 32'h00010203, 8'h3C,
                8'h3B, 1, 24, 8, 2);
    endtask

    task automatic t_quad();
        do_read("quad", 5'h04, 1'b0, 8'h0B, 8'h6B, 32'h00445566, 8'hC3,
                8'h6B, 1, 24, 8, 4);
    endtask

    task automatic t_dual_addr();
        do_read("dual-addr", 5'h03, 1'b0, 8'hBB, 8'hEB, 32'h00F0E1D2, 8'h96,
                8'hBB, 2, 24, 8, 2);
    endtask

    task automatic t_quad_addr4();
        do_read("quad-addr-4B", 5'h1C, 1'b0, 8'h0B, 8'hEC, 32'h89ABCDEF, 8'h71,
                8'hEC, 4, 32, 8, 4);
    endtask

    task automatic t_write();
        logic [31:0] an;
        int          falls0;
        setup(5'h04, 1'b1, 8'h0B, 8'h6B);
        bus_write(4'd2, 8'h5E);
        set_addr(32'h00000100);
        falls0 = cs_falls;
        run_cmd(8'h90);
        check_eq("R8 write opcode", {24'd0, take(0, 8, 1)}, 32'h02);
        check_eq("R8 write address", take(8, 24, 1), 32'h00000100);
        check_eq("R8 write data", {24'd0, take(32, 8, 1)}, 32'h5E);
        check_eq("R8 write clocks", nrise, 40);
        check_eq("R9 write data oe", {28'd0, tr_oe[32]}, 32'd1);
        check_eq("R8 single cs", cs_falls - falls0, 1);
        get_addr(an);
        check_eq("R10 write step", an, 32'h00000101);
    endtask

    task automatic t_sequence();
        setup(5'h00, 1'b1, 8'h0B, 8'h6B);
        set_addr(32'h00000010);
        m_dstart = 40; m_lanes = 1; m_byte = 8'h11;
        run_cmd(8'h81);
        check_eq("R10 first addr", take(8, 24, 1), 32'h10);
        m_byte = 8'h22;
        run_cmd(8'h81);
        check_eq("R10 second addr", take(8, 24, 1), 32'h11);
        m_dstart = 1000;
    endtask

    task automatic t_wrap();
        logic [31:0] an;
        setup(5'h00, 1'b0, 8'h03, 8'h6B);
        set_addr(32'hAAFFFFFF);
        run_cmd(8'h81);
        get_addr(an);
        check_eq("R11 wrap 24-bit", an, 32'hAA000000);
        setup(5'h10, 1'b0, 8'h03, 8'h6B);
        set_addr(32'h00FFFFFF);
        run_cmd(8'h81);
        get_addr(an);
        check_eq("R11 carry 32-bit", an, 32'h01000000);
        set_addr(32'hFFFFFFFF);
        run_cmd(8'h81);
        get_addr(an);
        check_eq("R11 wrap 32-bit", an, 32'h00000000);
    endtask

    task automatic t_busy_flag();
        logic [7:0]  v;
        logic [31:0] an;
        setup(5'h00, 1'b0, 8'h03, 8'h6B);
        set_addr(32'h00000200);
        bus_write(4'd0, 8'h81);
        bus_read(4'd0, v);
        check_eq("R2 busy readback", {24'd0, v}, 32'h81);
        bus_write(4'd5, 8'h77);
        for (int i = 0; i < 5000; i++) begin
            bus_read(4'd0, v);
            if (v == 8'd0) break;
        end
        check_eq("R2 cleared", {24'd0, v}, 32'd0);
        get_addr(an);
        check_eq("R2 busy write ignored", an, 32'h00000201);
    endtask

    task automatic t_bad_cmd();
        logic [7:0]  v;
        logic [31:0] an;
        int          falls0;
        set_addr(32'h00000300);
        falls0 = cs_falls;
        bus_write(4'd0, 8'h55);
        repeat (40) @(negedge clk);
        check_eq("R2 bad cmd no cs", cs_falls - falls0, 0);
        bus_read(4'd0, v);
        check_eq("R2 bad cmd reg", {24'd0, v}, 32'd0);
        get_addr(an);
        check_eq("R2 bad cmd addr", an, 32'h00000300);
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_fast();
        t_plain();
        t_dual();
        t_quad();
        t_dual_addr();
        t_quad_addr4();
        t_write();
        t_sequence();
        t_wrap();
        t_busy_flag();
        t_bad_cmd();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule